// File: doc/BRIEF.md
# Flexible serially concatenated LDPC encoder

This block encodes one frame of K information bits, where K is eight times a programmed byte count. Every information bit leaves at once on a systematic stream. In parallel, each bit feeds a two-state feed-forward outer code with tail-biting termination, whose 2K coded bits are stored. When the frame has been loaded, the stored bits are read back in an algorithmically permuted order. Each run of J permuted bits is folded into one single-parity-check bit. That bit drives a two-state accumulator, and the accumulator output forms the parity stream.

The code rate is J/(J+2) and is chosen by a rate code alone. The interleaver always spans 2K positions. A frame begins with a start strobe that captures the byte count and the rate code. A configuration the encoder cannot serve sets an error flag, and the encoder stays idle. Information bits arrive serially with a valid qualifier and may have gaps between them. Parity bits follow once the last information bit has been taken.

Top module: `scl_encoder`

## Requirements
- R1: After reset, busy, cfg_err, sys_valid and par_valid are all 0.
- R2: A start while idle is accepted when cfg_bytes lies in 3..MAX_BYTES, cfg_rate is 0..4 (J = 2, 4, 8, 16, 32), and cfg_rate 4 comes with an even cfg_bytes so that J divides 2K. On acceptance, busy is 1 and cfg_err is 0 in the next cycle. Any other start while idle sets cfg_err to 1 and leaves busy at 0 in the next cycle.
- R3: Exactly K information bits are taken, one in each cycle in which in_valid is 1 during loading. Each bit appears on sys_bit, with sys_valid 1, in the cycle after it is taken.
- R4: in_valid and in_bit have no effect while idle or while parity is being produced: sys_valid stays 0 and the parity of the frame in flight is unchanged.
- R5: The outer code gives, for information bit i, two equal coded bits c[2i] = c[2i+1] = b[i] XOR b[i-1]. For i = 0 the previous bit is b[K-1] (tail-biting).
- R6: Permuted position j (0 <= j < 2K) reads coded bit c[(A*j + 5) mod 2K]. A is 13, or 17 when cfg_bytes is a multiple of 13.
- R7: For each group v of J consecutive permuted bits, parity p[v] = p[v-1] XOR (XOR of the group), with p[-1] = 0. A frame yields exactly 2K/J parity bits.
- R8: Parity bit v appears with par_valid 1 exactly J*(v+1) cycles after the clock edge that takes the last information bit. busy falls in the same cycle as the last parity bit, and sys_valid and par_valid are never 1 together.
- R9: A start strobe while busy is ignored. The frame in flight completes unchanged, and no new frame is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame-start strobe; samples the configuration |
| cfg_bytes | input | BYTES_W | Information length in bytes |
| cfg_rate | input | 3 | Rate code, J = 2 << cfg_rate |
| in_valid | input | 1 | Information bit qualifier |
| in_bit | input | 1 | Serial information bit |
| busy | output | 1 | Frame loading or parity in progress |
| cfg_err | output | 1 | Last start carried an unusable configuration |
| sys_valid | output | 1 | Systematic bit valid |
| sys_bit | output | 1 | Systematic bit |
| par_valid | output | 1 | Parity bit valid |
| par_bit | output | 1 | Parity bit |

## Verification
The systematic bit is due one cycle after the edge that takes it, and the error flag and busy are due one cycle after the start strobe. Parity bit v is due J*(v+1) cycles after the edge that takes the last information bit. The bench drives inputs and samples outputs on the falling edge. It keeps a free-running cycle counter, records the count at which each parity bit is seen, and compares it with the count at the last accepted bit plus J*(v+1). Expected parity comes from a software model of the outer code, the permutation and the accumulator.

// File: rtl/scl_pkg.sv
// Shared types and helpers for the serially concatenated LDPC encoder.
// Assumes rate codes 0..4 map to group sizes J = 2, 4, 8, 16, 32.
package scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_EMIT
    } scl_phase_e;

    localparam int          RATE_W   = 3;
    localparam int          GRP_W    = 5;
    localparam logic [2:0]  RATE_J32 = 3'd4;

    // True for rate codes the encoder can serve.
    function automatic logic rate_code_ok(input logic [RATE_W-1:0] code);
        return code <= RATE_J32;
    endfunction

    // J-1 for a rate code: the terminal value of the group counter.
    function automatic logic [GRP_W-1:0] group_mask(input logic [RATE_W-1:0] code);
        logic [GRP_W-1:0] m;
        case (code)
            3'd0:    m = 5'd1;
            3'd1:    m = 5'd3;
            3'd2:    m = 5'd7;
            3'd3:    m = 5'd15;
            default: m = 5'd31;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/scl_outer.sv
// Tail-biting outer code with taps 1+D on both outputs.
// Both coded bits of information bit i equal b[i]^b[i-1], so only one
// difference bit per information bit is produced. Bit 0's difference
// needs b[K-1]; it is formed when the last bit arrives and held in d0.
// Assumes first and last never coincide (K >= 24).
module scl_outer (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic first,
    input  logic last,
    input  logic in_bit,
    output logic sys_valid,
    output logic sys_bit,
    output logic wr_en,
    output logic wr_bit,
    output logic d0
);

    logic prev_q;
    logic head_q;

    // Difference bits for positions 1..K-1 go straight to the store.
    assign wr_en  = accept && !first;
    assign wr_bit = in_bit ^ prev_q;

    // Track the previous bit, the frame's first bit and the wrapped difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            head_q <= 1'b0;
            d0     <= 1'b0;
        end else if (accept) begin
            prev_q <= in_bit;
            if (first) head_q <= in_bit;
            if (last)  d0     <= head_q ^ in_bit;
        end
    end

    // Systematic stream: one cycle behind the accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_valid <= 1'b0;
            sys_bit   <= 1'b0;
        end else begin
            sys_valid <= accept;
            sys_bit   <= accept ? in_bit : sys_bit;
        end
    end

    assert_tailbite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (d0 == ($past(in_bit) ^ head_q)));

    assert_sys_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sys_valid && sys_bit == $past(in_bit)));

endmodule

// File: rtl/scl_store.sv
// Holds the K outer-code difference bits of one frame.
// A coded address selects entry addr>>1 (both coded copies are equal);
// entry 0 is taken from the d0 input, which is only known at frame end.
// Assumes the write index never reaches DEPTH.
module scl_store #(
    parameter int DEPTH  = 512,
    parameter int IDX_W  = 9,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              d0,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);

    logic             mem [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic             unused_lsb;

    // Write one difference bit per accepted information bit.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_bit;
    end

    // Read the difference bit behind a coded position.
    always_comb begin
        rd_idx     = rd_addr[ADDR_W-1:1];
        unused_lsb = rd_addr[0];
        rd_bit     = (rd_idx == '0) ? d0 : mem[rd_idx];
    end

endmodule

// File: rtl/scl_perm.sv
// Permutation address generator: walks j = 0..n-1 and gives
// (step*j + OFS) mod n incrementally with one add and one compare.
// Assumes step < n and OFS < n, so a single subtraction wraps the sum.
module scl_perm #(
    parameter int CNT_W  = 11,
    parameter int ADDR_W = 10,
    parameter int OFS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CNT_W-1:0]  n_len,
    input  logic [CNT_W-1:0]  step,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   wrapped;

    assign last = active && (pos_q == n_len - CNT_W'(1));

    // Next address modulo n.
    always_comb begin
        sum     = (CNT_W+1)'(addr) + (CNT_W+1)'(step);
        wrapped = (sum >= (CNT_W+1)'(n_len)) ? sum - (CNT_W+1)'(n_len) : sum;
    end

    // Step through the permuted positions of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            addr   <= '0;
            pos_q  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            addr   <= ADDR_W'(OFS);
            pos_q  <= '0;
        end else if (active) begin
            addr   <= ADDR_W'(wrapped);
            pos_q  <= pos_q + CNT_W'(1);
            if (last) active <= 1'b0;
        end
    end

    assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (CNT_W'(addr) < n_len));

endmodule

// File: rtl/scl_spc_acc.sv
// Single-parity-check combiner followed by the 1/(1+D) accumulator.
// Folds J permuted bits into one check, and emits the running XOR of
// the checks, one parity bit per group. Unterminated: it starts from 0.
// Assumes bit_valid is contiguous for a whole frame after clear.
module scl_spc_acc #(
    parameter int GRP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [GRP_W-1:0] jmask,
    output logic             par_valid,
    output logic             par_bit
);

    logic [GRP_W-1:0] grp_q;
    logic             chk_q;
    logic             acc_q;
    logic             chk_nx;

    assign chk_nx = chk_q ^ bit_in;

    // Group counting, check folding and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q     <= '0;
            chk_q     <= 1'b0;
            acc_q     <= 1'b0;
            par_valid <= 1'b0;
            par_bit   <= 1'b0;
        end else begin
            par_valid <= 1'b0;
            if (clear) begin
                grp_q <= '0;
                chk_q <= 1'b0;
                acc_q <= 1'b0;
            end else if (bit_valid) begin
                if (grp_q == jmask) begin
                    grp_q     <= '0;
                    chk_q     <= 1'b0;
                    acc_q     <= acc_q ^ chk_nx;
                    par_bit   <= acc_q ^ chk_nx;
                    par_valid <= 1'b1;
                end else begin
                    grp_q <= grp_q + GRP_W'(1);
                    chk_q <= chk_nx;
                end
            end
        end
    end

    assert_par_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |=> !par_valid);

    assert_par_is_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> (par_bit == acc_q));

endmodule

// File: rtl/scl_encoder.sv
// Top of the serially concatenated LDPC encoder.
// Sequences a frame: idle -> load K bits -> emit 2K/J parity bits.
// Validates the configuration on start and picks the permutation step.
// Assumes MUL_A and MUL_B are distinct odd primes below 48 whose product
// exceeds MAX_BYTES, so one of them is always coprime to 2K.
module scl_encoder
    import scl_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int MIN_BYTES = 3,
    parameter int MUL_A     = 13,
    parameter int MUL_B     = 17,
    parameter int PERM_OFS  = 5,
    localparam int MAX_BITS = 8 * MAX_BYTES,
    localparam int BYTES_W  = $clog2(MAX_BYTES + 1),
    localparam int IDX_W    = $clog2(MAX_BITS),
    localparam int ADDR_W   = $clog2(2 * MAX_BITS),
    localparam int CNT_W    = $clog2(2 * MAX_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTES_W-1:0] cfg_bytes,
    input  logic [2:0]         cfg_rate,
    input  logic               in_valid,
    input  logic               in_bit,
    output logic               busy,
    output logic               cfg_err,
    output logic               sys_valid,
    output logic               sys_bit,
    output logic               par_valid,
    output logic               par_bit
);

    scl_phase_e         phase;
    logic [CNT_W-1:0]   k_q;
    logic [CNT_W-1:0]   n_q;
    logic [CNT_W-1:0]   step_q;
    logic [GRP_W-1:0]   jmask_q;
    logic [CNT_W-1:0]   in_cnt;
    logic               cfg_ok;
    logic [CNT_W-1:0]   step_sel;
    logic               accept;
    logic               first_in;
    logic               last_in;
    logic               wr_en;
    logic               wr_bit;
    logic               d0;
    logic               perm_active;
    logic [ADDR_W-1:0]  perm_addr;
    logic               perm_last;
    logic               rd_bit;

    // Configuration check and permutation multiplier choice.
    always_comb begin
        cfg_ok = rate_code_ok(cfg_rate)
              && (int'(cfg_bytes) >= MIN_BYTES)
              && (int'(cfg_bytes) <= MAX_BYTES)
              && !(cfg_rate == RATE_J32 && cfg_bytes[0]);
        step_sel = ((int'(cfg_bytes) % MUL_A) == 0) ? CNT_W'(MUL_B) : CNT_W'(MUL_A);
    end

    assign accept   = (phase == PH_LOAD) && in_valid;
    assign first_in = accept && (in_cnt == '0);
    assign last_in  = accept && (in_cnt == k_q - CNT_W'(1));
    assign busy     = (phase != PH_IDLE);
    assign cfg_err  = cfg_err_q;

    logic cfg_err_q;

    // Frame sequencing and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            k_q       <= '0;
            n_q       <= '0;
            step_q    <= '0;
            jmask_q   <= '0;
            in_cnt    <= '0;
            cfg_err_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            phase     <= PH_LOAD;
                            k_q       <= CNT_W'(cfg_bytes) << 3;
                            n_q       <= CNT_W'(cfg_bytes) << 4;
                            step_q    <= step_sel;
                            jmask_q   <= group_mask(cfg_rate);
                            in_cnt    <= '0;
                            cfg_err_q <= 1'b0;
                        end else begin
                            cfg_err_q <= 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (accept) begin
                        in_cnt <= in_cnt + CNT_W'(1);
                        if (last_in) phase <= PH_EMIT;
                    end
                end
                PH_EMIT: begin
                    if (perm_last) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    scl_outer u_outer (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .first     (first_in),
        .last      (last_in),
        .in_bit    (in_bit),
        .sys_valid (sys_valid),
        .sys_bit   (sys_bit),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .d0        (d0)
    );

    scl_store #(
        .DEPTH  (MAX_BITS),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (in_cnt[IDX_W-1:0]),
        .wr_bit  (wr_bit),
        .d0      (d0),
        .rd_addr (perm_addr),
        .rd_bit  (rd_bit)
    );

    scl_perm #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .OFS    (PERM_OFS)
    ) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (last_in),
        .n_len  (n_q),
        .step   (step_q),
        .active (perm_active),
        .addr   (perm_addr),
        .last   (perm_last)
    );

    scl_spc_acc #(
        .GRP_W (GRP_W)
    ) u_spc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (last_in),
        .bit_valid (perm_active),
        .bit_in    (rd_bit),
        .jmask     (jmask_q),
        .par_valid (par_valid),
        .par_bit   (par_bit)
    );

    assert_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && cfg_err));

    assert_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start && !cfg_ok) |=> (cfg_err && !busy));

    assert_idle_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && in_valid) |=> !sys_valid);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_valid && par_valid));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EMIT && start) |=> (phase != PH_LOAD));

endmodule

// File: tb/sim_scl_encoder.sv
`timescale 1ns/1ps
module sim_scl_encoder;

    localparam int MAX_BYTES = 64;
    localparam int BYTES_W   = $clog2(MAX_BYTES + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [BYTES_W-1:0] cfg_bytes = '0;
    logic [2:0]         cfg_rate = '0;
    logic               in_valid = 1'b0;
    logic               in_bit = 1'b0;
    logic               busy, cfg_err, sys_valid, sys_bit, par_valid, par_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pcount = 0;
    int scount = 0;
    bit par_got [1024];
    int par_cyc [1024];
    bit info [512];
    bit exp_par [1024];
    logic [31:0] lfsr = 32'hACE1_2467;

    scl_encoder #(.MAX_BYTES(MAX_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_bytes(cfg_bytes),
        .cfg_rate(cfg_rate), .in_valid(in_valid), .in_bit(in_bit),
        .busy(busy), .cfg_err(cfg_err), .sys_valid(sys_valid), .sys_bit(sys_bit),
        .par_valid(par_valid), .par_bit(par_bit)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor on the falling edge.
    always @(negedge clk) begin
        if (par_valid) begin
            if (pcount < 1024) begin
                par_got[pcount] = par_bit;
                par_cyc[pcount] = cyc;
            end
            pcount = pcount + 1;
        end
        if (sys_valid) scount = scount + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit rnd_bit();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    // Reference model of outer code, permutation and accumulator.
    task automatic build_expect(input int nbytes, input int code);
        int k = 8 * nbytes;
        int n = 2 * k;
        int jg = 2 << code;
        int mul = ((nbytes % 13) == 0) ? 17 : 13;
        bit chk = 0;
        bit acc = 0;
        for (int j = 0; j < n; j++) begin
            int a = (mul * j + 5) % n;
            int i = a / 2;
            chk = chk ^ info[i] ^ info[(i + k - 1) % k];
            if ((j % jg) == jg - 1) begin
                acc = acc ^ chk;
                exp_par[j / jg] = acc;
                chk = 0;
            end
        end
    endtask

    // One frame: load with optional gaps, optional pokes while emitting.
    task automatic run_frame(input int nbytes, input int code, input int pat,
                             input bit gaps, input bit poke, input string tag);
        int k = 8 * nbytes;
        int jg = 2 << code;
        int v = (2 * k) / jg;
        int sys_bad = 0;
        int val_bad = 0;
        int cyc_bad = 0;
        int last_cyc;
        for (int i = 0; i < k; i++) begin
            case (pat)
                0: info[i] = rnd_bit();
                1: info[i] = 1'b1;
                default: info[i] = (i == k - 1);
            endcase
        end
        build_expect(nbytes, code);
        pcount = 0;
        scount = 0;
        @(negedge clk);
        start = 1'b1; cfg_bytes = BYTES_W'(nbytes); cfg_rate = 3'(code);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && cfg_err == 1'b0, "R2", {tag, " accepted start"},
              int'({busy, cfg_err}), 2);
        for (int i = 0; i < k; i++) begin
            if (gaps && (i % 5) == 2) begin
                in_valid = 1'b0; in_bit = 1'b1;
                @(negedge clk);
                if (sys_valid) sys_bad++;
            end
            in_valid = 1'b1; in_bit = info[i];
            @(negedge clk);
            if (!(sys_valid && sys_bit == info[i])) sys_bad++;
        end
        in_valid = 1'b0;
        last_cyc = cyc;
        if (poke) begin
            for (int c = 0; c < 6; c++) begin
                start = 1'b1; cfg_bytes = BYTES_W'(3); cfg_rate = 3'd0;
                in_valid = 1'b1; in_bit = rnd_bit();
                @(negedge clk);
            end
            start = 1'b0; in_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sys_bad == 0, "R3", {tag, " systematic echo mismatches"}, sys_bad, 0);
        check(scount == k, "R4", {tag, " systematic bit count"}, scount, k);
        check(pcount == v, "R7", {tag, " parity bit count"}, pcount, v);
        for (int p = 0; p < v && p < 1024; p++) begin
            if (par_got[p] != exp_par[p]) val_bad++;
            if (par_cyc[p] != last_cyc + jg * (p + 1)) cyc_bad++;
        end
        check(val_bad == 0, "R5 R6 R7", {tag, " parity value mismatches"}, val_bad, 0);
        check(cyc_bad == 0, "R8", {tag, " parity timing mismatches"}, cyc_bad, 0);
        check(busy == 1'b0 && cfg_err == 1'b0, "R9", {tag, " idle after frame"},
              int'({busy, cfg_err}), 0);
    endtask

    // Unusable configuration: error flag set, no frame started.
    task automatic bad_cfg(input int nbytes, input int code, input string tag);
        int stray = 0;
        @(negedge clk);
        start = 1'b1; cfg_bytes = BYTES_W'(nbytes); cfg_rate = 3'(code);
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b1 && busy == 1'b0, "R2", {tag, " rejected start"},
              int'({busy, cfg_err}), 1);
        for (int c = 0; c < 4; c++) begin
            in_valid = 1'b1; in_bit = 1'b1;
            @(negedge clk);
            if (sys_valid) stray++;
        end
        in_valid = 1'b0;
        check(stray == 0, "R4", {tag, " bits ignored after reject"}, stray, 0);
    endtask

    // Bits offered while idle must not appear.
    task automatic idle_ignore();
        int stray = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_bit = rnd_bit();
            if (sys_valid || busy) stray++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (sys_valid || busy) stray++;
        check(stray == 0, "R4", "idle input ignored", stray, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, cfg_err, sys_valid, par_valid} == 4'b0000, "R1", "reset state",
              int'({busy, cfg_err, sys_valid, par_valid}), 0);
        idle_ignore();
        run_frame(3, 0, 0, 1'b0, 1'b0, "J2 min length");
        run_frame(13, 1, 0, 1'b1, 1'b0, "J4 alt multiplier gaps");
        run_frame(64, 3, 0, 1'b0, 1'b0, "J16 max length");
        run_frame(4, 4, 0, 1'b0, 1'b1, "J32 with pokes");
        run_frame(8, 2, 1, 1'b1, 1'b0, "J8 all ones");
        run_frame(5, 1, 2, 1'b0, 1'b0, "J4 tail bit only");
        bad_cfg(2, 0, "short frame");
        bad_cfg(65, 1, "long frame");
        bad_cfg(8, 5, "bad rate code");
        bad_cfg(3, 4, "J32 odd bytes");
        run_frame(26, 0, 0, 1'b0, 1'b0, "J2 after reject");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule